// File: doc/BRIEF.md
# Branch and Next-PC Unit

This unit chooses the next fetch address for a 32-bit RISC core. Each cycle it takes the instruction word, the address of that instruction and the values of the two registers named by the instruction's first and second register fields. It returns the next program counter, a flag that marks a change of flow, and a link write request with its data and destination index.

Decoding sorts the 6-bit opcode into one of six kinds: sequential, register jump, offset jump, register call, offset call and compare-and-branch. Compare-and-branch carries one of six conditions. Two instances of an offset adder form the short (16-bit word offset) and long (26-bit word offset) targets. A comparator evaluates the condition. A selection stage picks the result. All outputs are registered, so a result appears one clock after its inputs are sampled. There is no state machine. The decoded kind plays the part of the state in a single `unique case`.

The register-indirect return forms are plain register jumps here. Fetch, the register file and exception handling lie outside the unit.

Top module: `npc_unit`

## Requirements
- R1: While reset is asserted (rst_n low), pc_next, redirect, link_we and link_data are all zero.
- R2: Opcode 48 (insn bits 31:26) sets pc_next to opnd_a with redirect high and link_we low.
- R3: Opcode 56 sets pc_next to the PC plus insn bits 25:0 sign-extended and multiplied by 4, with redirect high and link_we low.
- R4: Opcode 54 (target opnd_a) and opcode 62 (target as in R3) set redirect high, link_we high, link_data to PC+4 and link_idx to 29. link_data is zero whenever link_we is low.
- R5: Opcode 17 branches when opnd_a equals opnd_b. Opcode 23 branches when they differ.
- R6: Opcode 18 branches when opnd_a is greater than opnd_b as signed two's complement. Opcode 19 branches when it is greater or equal.
- R7: Opcode 21 branches when opnd_a is greater than opnd_b as unsigned. Opcode 20 branches when it is greater or equal.
- R8: A branch whose condition holds sets pc_next to the PC plus insn bits 15:0 sign-extended and multiplied by 4, with redirect high and link_we low.
- R9: A branch whose condition fails gives pc_next = PC+4 with redirect and link_we low.
- R10: Any other opcode gives pc_next = PC+4 with redirect and link_we low.
- R11: Outputs update on the rising edge after the inputs are presented and hold until the next edge. Addition wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| insn | input | 32 | Instruction word |
| pc_now | input | 32 | Address of the instruction |
| opnd_a | input | 32 | Value of register named by bits 25:21 |
| opnd_b | input | 32 | Value of register named by bits 20:16 |
| pc_next | output | 32 | Next program counter |
| redirect | output | 1 | Change of flow taken |
| link_we | output | 1 | Link register write request |
| link_idx | output | 5 | Link register index (29) |
| link_data | output | 32 | Return address to write |

## Verification
The bench builds the unit with its default parameters: 32-bit data, a 16-bit branch offset, a 26-bit jump offset and link index 29. With these values, a 32-bit random operand reaches both ends of every offset's sign range. It also exposes operand pairs on which the signed and unsigned comparisons disagree. Random operand pairs are forced equal a quarter of the time, so that the greater-or-equal and equality conditions hit their boundary.

// File: rtl/npc_pkg.sv
package npc_pkg;
    localparam int OPC_W = 6;

    typedef enum logic [2:0] {
        K_SEQ,
        K_JREG,
        K_JOFS,
        K_CREG,
        K_COFS,
        K_BR
    } kind_e;

    typedef enum logic [2:0] {
        C_EQ,
        C_NE,
        C_SGT,
        C_SGE,
        C_UGT,
        C_UGE
    } cond_e;

    localparam logic [OPC_W-1:0] OP_JREG = 6'd48;
    localparam logic [OPC_W-1:0] OP_JOFS = 6'd56;
    localparam logic [OPC_W-1:0] OP_CREG = 6'd54;
    localparam logic [OPC_W-1:0] OP_COFS = 6'd62;
    localparam logic [OPC_W-1:0] OP_BEQ  = 6'd17;
    localparam logic [OPC_W-1:0] OP_BNE  = 6'd23;
    localparam logic [OPC_W-1:0] OP_BSGT = 6'd18;
    localparam logic [OPC_W-1:0] OP_BSGE = 6'd19;
    localparam logic [OPC_W-1:0] OP_BUGE = 6'd20;
    localparam logic [OPC_W-1:0] OP_BUGT = 6'd21;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    output kind_e            kind,
    output cond_e            cond
);
    always_comb begin
        kind = K_SEQ;
        cond = C_EQ;
        unique case (opc)
            OP_JREG: kind = K_JREG;
            OP_JOFS: kind = K_JOFS;
            OP_CREG: kind = K_CREG;
            OP_COFS: kind = K_COFS;
            OP_BEQ:  begin kind = K_BR; cond = C_EQ;  end
            OP_BNE:  begin kind = K_BR; cond = C_NE;  end
            OP_BSGT: begin kind = K_BR; cond = C_SGT; end
            OP_BSGE: begin kind = K_BR; cond = C_SGE; end
            OP_BUGT: begin kind = K_BR; cond = C_UGT; end
            OP_BUGE: begin kind = K_BR; cond = C_UGE; end
            default: ;
        endcase
    end
endmodule

// File: rtl/npc_compare.sv
module npc_compare
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  cond_e           cond,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic            hit
);
    always_comb begin
        hit = 1'b0;
        unique case (cond)
            C_EQ:  hit = (a == b);
            C_NE:  hit = (a != b);
            C_SGT: hit = ($signed(a) >  $signed(b));
            C_SGE: hit = ($signed(a) >= $signed(b));
            C_UGT: hit = (a >  b);
            C_UGE: hit = (a >= b);
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/npc_ofs_add.sv
module npc_ofs_add #(
    parameter int XLEN  = 32,
    parameter int OFS_W = 16
) (
    input  logic [XLEN-1:0]  base,
    input  logic [OFS_W-1:0] ofs,
    output logic [XLEN-1:0]  sum
);
    localparam int EXT_W = XLEN - OFS_W - 2;

    logic [XLEN-1:0] scaled;
    assign scaled = {{EXT_W{ofs[OFS_W-1]}}, ofs, 2'b00};
    assign sum    = base + scaled;
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int INSN_W   = 32,
    parameter int BOFS_W   = 16,
    parameter int JOFS_W   = 26,
    parameter int RIDX_W   = 5,
    parameter int LINK_IDX = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INSN_W-1:0] insn,
    input  logic [XLEN-1:0]   pc_now,
    input  logic [XLEN-1:0]   opnd_a,
    input  logic [XLEN-1:0]   opnd_b,
    output logic [XLEN-1:0]   pc_next,
    output logic              redirect,
    output logic              link_we,
    output logic [RIDX_W-1:0] link_idx,
    output logic [XLEN-1:0]   link_data
);
    localparam int              OPC_LSB = INSN_W - OPC_W;
    localparam logic [XLEN-1:0] STEP    = XLEN'(4);

    logic [OPC_W-1:0] opc;
    kind_e            kind;
    cond_e            cond;
    logic             hit;
    logic [XLEN-1:0]  seq_pc, br_tgt, j_tgt;
    logic [XLEN-1:0]  nx_pc;
    logic             nx_tk, nx_lw;
    logic             primed;

    assign opc    = insn[INSN_W-1:OPC_LSB];
    assign seq_pc = pc_now + STEP;

    npc_decode u_dec (.opc(opc), .kind(kind), .cond(cond));

    npc_compare #(.XLEN(XLEN)) u_cmp (
        .cond(cond), .a(opnd_a), .b(opnd_b), .hit(hit)
    );

    npc_ofs_add #(.XLEN(XLEN), .OFS_W(BOFS_W)) u_br_tgt (
        .base(pc_now), .ofs(insn[BOFS_W-1:0]), .sum(br_tgt)
    );

    npc_ofs_add #(.XLEN(XLEN), .OFS_W(JOFS_W)) u_j_tgt (
        .base(pc_now), .ofs(insn[JOFS_W-1:0]), .sum(j_tgt)
    );

    always_comb begin
        nx_pc = seq_pc;
        nx_tk = 1'b0;
        nx_lw = 1'b0;
        unique case (kind)
            K_JREG: begin nx_pc = opnd_a; nx_tk = 1'b1; end
            K_CREG: begin nx_pc = opnd_a; nx_tk = 1'b1; nx_lw = 1'b1; end
            K_JOFS: begin nx_pc = j_tgt;  nx_tk = 1'b1; end
            K_COFS: begin nx_pc = j_tgt;  nx_tk = 1'b1; nx_lw = 1'b1; end
            K_BR: begin
                if (hit) begin
                    nx_pc = br_tgt;
                    nx_tk = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_next   <= '0;
            redirect  <= 1'b0;
            link_we   <= 1'b0;
            link_data <= '0;
            primed    <= 1'b0;
        end else begin
            pc_next   <= nx_pc;
            redirect  <= nx_tk;
            link_we   <= nx_lw;
            link_data <= nx_lw ? seq_pc : '0;
            primed    <= 1'b1;
        end
    end

    assign link_idx = RIDX_W'(LINK_IDX);

    a_r9_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !redirect) |-> (pc_next == $past(pc_now) + STEP));

    a_r4_link_data: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && link_we) |-> (redirect && link_data == $past(pc_now) + STEP));

    a_r2_reg_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(opc) == OP_JREG) |-> (pc_next == $past(opnd_a) && !link_we));

    a_r10_plain_op: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(kind) == K_SEQ) |-> (!redirect && !link_we));

    a_r5_equal_branch: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(opc) == OP_BEQ && $past(opnd_a) == $past(opnd_b)) |-> redirect);
endmodule

// File: tb/npc_unit_tb.sv
module npc_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] insn = '0, pc_now = '0, opnd_a = '0, opnd_b = '0;
    logic [31:0] pc_next, link_data;
    logic        redirect, link_we;
    logic [4:0]  link_idx;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    npc_unit u_dut (
        .clk(clk), .rst_n(rst_n), .insn(insn), .pc_now(pc_now),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .pc_next(pc_next),
        .redirect(redirect), .link_we(link_we), .link_idx(link_idx),
        .link_data(link_data)
    );

    function automatic void model(input logic [31:0] i, pc, a, b,
                                  output logic [31:0] npc, output logic tk,
                                  output logic lw, output logic [31:0] ld);
        logic [31:0] seq, boff, joff;
        logic c;
        seq  = pc + 32'd4;
        boff = {{14{i[15]}}, i[15:0], 2'b00};
        joff = {{4{i[25]}}, i[25:0], 2'b00};
        npc = seq; tk = 1'b0; lw = 1'b0; c = 1'b0;
        case (i[31:26])
            6'd48: begin npc = a; tk = 1'b1; end
            6'd54: begin npc = a; tk = 1'b1; lw = 1'b1; end
            6'd56: begin npc = pc + joff; tk = 1'b1; end
            6'd62: begin npc = pc + joff; tk = 1'b1; lw = 1'b1; end
            6'd17, 6'd23, 6'd18, 6'd19, 6'd20, 6'd21: begin
                case (i[31:26])
                    6'd17: c = (a == b);
                    6'd23: c = (a != b);
                    6'd18: c = ($signed(a) > $signed(b));
                    6'd19: c = ($signed(a) >= $signed(b));
                    6'd21: c = (a > b);
                    default: c = (a >= b);
                endcase
                if (c) begin npc = pc + boff; tk = 1'b1; end
            end
            default: ;
        endcase
        ld = lw ? seq : 32'd0;
    endfunction

    function automatic logic [31:0] mk_br(input logic [5:0] op, input logic [15:0] ofs);
        return {op, 5'd3, 5'd4, ofs};
    endfunction

    function automatic logic [31:0] mk_j(input logic [5:0] op, input logic [25:0] ofs);
        return {op, ofs};
    endfunction

    task automatic apply(input logic [31:0] i, pc, a, b, input string tag);
        logic [31:0] e_pc, e_ld;
        logic e_tk, e_lw;
        @(negedge clk);
        insn = i; pc_now = pc; opnd_a = a; opnd_b = b;
        @(posedge clk);
        @(negedge clk);
        model(i, pc, a, b, e_pc, e_tk, e_lw, e_ld);
        n_vec++;
        if (pc_next !== e_pc || redirect !== e_tk || link_we !== e_lw ||
            link_data !== e_ld || link_idx !== 5'd29) begin
            n_bad++;
            $display("FAIL %s insn=%h: got pc=%h tk=%b lw=%b ld=%h idx=%0d exp pc=%h tk=%b lw=%b ld=%h idx=29",
                     tag, i, pc_next, redirect, link_we, link_data, link_idx,
                     e_pc, e_tk, e_lw, e_ld);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [5:0] ops [12];
        ops = '{6'd48, 6'd56, 6'd54, 6'd62, 6'd17, 6'd23, 6'd18, 6'd19,
                6'd20, 6'd21, 6'd45, 6'd13};
        void'($urandom(32'h5EED));
        insn = mk_j(6'd62, 26'h1);
        pc_now = 32'h100;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        n_vec++;
        if (pc_next !== 0 || redirect !== 0 || link_we !== 0 || link_data !== 0) begin
            n_bad++;
            $display("FAIL R1 got pc=%h tk=%b lw=%b ld=%h exp all zero",
                     pc_next, redirect, link_we, link_data);
        end
        rst_n = 1'b1;

        apply({6'd48, 26'h0}, 32'h1000, 32'hDEAD_BEE0, 32'h0, "R2");
        apply(mk_j(6'd56, 26'h3FF_FFFF), 32'h2000, 0, 0, "R3");
        apply(mk_j(6'd56, 26'h200_0000), 32'h0000_0010, 0, 0, "R3");
        apply({6'd54, 26'h0}, 32'h3000, 32'h0000_4000, 0, "R4");
        apply(mk_j(6'd62, 26'h10), 32'hFFFF_FFFC, 0, 0, "R4");
        apply(mk_br(6'd17, 16'h0008), 32'h500, 32'd7, 32'd7, "R5");
        apply(mk_br(6'd17, 16'h0008), 32'h500, 32'd7, 32'd8, "R9");
        apply(mk_br(6'd23, 16'hFFFF), 32'h500, 32'd1, 32'd2, "R5");
        apply(mk_br(6'd18, 16'h0004), 32'h600, 32'h0000_0001, 32'hFFFF_FFFF, "R6");
        apply(mk_br(6'd19, 16'h0004), 32'h600, 32'h8000_0000, 32'h8000_0000, "R6");
        apply(mk_br(6'd21, 16'h0004), 32'h600, 32'h0000_0001, 32'hFFFF_FFFF, "R7");
        apply(mk_br(6'd20, 16'h0004), 32'h600, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R7");
        apply(mk_br(6'd19, 16'h8000), 32'h0001_0000, 32'd5, 32'd5, "R8");
        apply(mk_br(6'd45, 16'h1234), 32'h700, 32'd1, 32'd1, "R10");
        apply(mk_br(6'd13, 16'h0000), 32'hFFFF_FFFC, 32'd0, 32'd0, "R10");

        for (int k = 0; k < 3000; k++) begin
            logic [31:0] r, a, b;
            r = $urandom;
            a = $urandom;
            b = ($urandom % 4 == 0) ? a : $urandom;
            if ($urandom % 5 != 0) r[31:26] = ops[$urandom % 12];
            apply(r, {$urandom} & 32'hFFFF_FFFC, a, b, "R11");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule